// File: doc/BRIEF.md
# I2C Master Command and Acknowledge Sequencer

This block is the control front end of an I2C master. A register write path delivers a 4-bit control field. That field carries a flush strobe, an acknowledge-action bit and a 2-bit command. Reads and writes of the master data register arrive as single-cycle pulses. The block turns these events into an ordered series of requests to a byte-level bus engine. Each request carries one opcode: ACK, NACK, repeated START, read byte, write byte or STOP. SCL/SDA timing and the address phase belong to the engine. An address write opens a transaction here and latches the transfer direction from its R/W bit.

A command first sends the programmed acknowledge response to the last received byte, and then a chained bus action. The acknowledge response is sent only in read direction. In smart mode, a read of the data register starts the acknowledge and the next byte read by itself. A flush drops every piece of transaction state at once. The block tracks the bus state as idle, owner (this master holds the bus) or busy (another master holds it). A sticky error flag records writes it had to refuse.

The engine request is a valid/ready stream. `req_valid` and `req_op` stay stable until `req_ready` is sampled high. Back-pressure from the engine therefore only stretches the request. Once a request is accepted, nothing further is issued until the engine pulses `eng_done`.

Top module: `i2c_cmd_ctrl`

## Requirements
- R1: After reset, `bus_state` is 0 (idle), `req_valid`, `cmd_err` and `dir_read` are 0, and `ctrl_rdata` is 0.
- R2: `ctrl_rdata` bit 2 returns the last written acknowledge bit. Bits 1:0 (command) and bit 3 (flush) always read 0.
- R3: Opcodes on `req_op` are ACK=0, NACK=1, RSTART=2, RDBYTE=3, WRBYTE=4, STOP=5. In read direction every command issues ACK (ack bit 0) or NACK (ack bit 1) before its follow-on request. In write direction no ACK/NACK request is issued.
- R4: Command values written to bits 1:0 work as follows. 1 issues RSTART. 2 issues RDBYTE in read direction and WRBYTE in write direction. 3 issues STOP, and `bus_state` returns to idle after the engine finishes it. 0 issues nothing and raises no error.
- R5: When the ack bit and a command are written together, the newly written ack value selects ACK or NACK for that command.
- R6: With `smart_en` high, in read direction and owner state with no sequence running, a `data_rd` pulse issues ACK/NACK then RDBYTE. With `smart_en` low, `data_rd` issues nothing.
- R7: A `data_wr` pulse never issues an ACK/NACK request.
- R8: WRBYTE is held back until `data_wr` has occurred since the address write or the previous WRBYTE. If that data is already present, WRBYTE is issued at once.
- R9: `req_valid` and `req_op` hold steady while `req_ready` is low. No request follows an accepted one before `eng_done`. An `eng_done` pulse with no request outstanding has no effect.
- R10: Writing 1 to bit 3 (flush) drops any pending request, returns `bus_state` to idle, clears `cmd_err` and discards pending write data. A command in the same write is ignored. Writing 0 to bit 3 changes nothing.
- R11: A non-zero command is refused, and `cmd_err` is set and stays set until a flush, in two cases: the master is not in owner state, or a sequence is still running. An address write while the bus is busy or a sequence runs is refused in the same way.
- R12: After a flush, commands are refused until a new address write reopens a transaction.
- R13: If a command write and a smart-mode `data_rd` fall in the same cycle, only the command's sequence runs.
- R14: In idle state, `ext_busy` high moves `bus_state` to 2 (busy). `ext_busy` low returns it to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smart_en | input | 1 | Smart-mode enable |
| ext_busy | input | 1 | Another master holds the bus |
| ctrl_wr | input | 1 | Control field write strobe |
| ctrl_wdata | input | 4 | Bit 3 flush, bit 2 ack action, bits 1:0 command |
| ctrl_rdata | output | 4 | Control field read value |
| addr_wr | input | 1 | Address register write strobe |
| addr_rw | input | 1 | R/W bit of the address byte (1 = read) |
| data_wr | input | 1 | Data register write strobe |
| data_rd | input | 1 | Data register read strobe |
| req_valid | output | 1 | Engine request valid |
| req_ready | input | 1 | Engine accepts request |
| req_op | output | 3 | Engine request opcode |
| eng_done | input | 1 | Engine finished the accepted request |
| bus_state | output | 2 | 0 idle, 1 owner, 2 busy |
| dir_read | output | 1 | Latched transfer direction (1 = read) |
| cmd_err | output | 1 | Sticky refused-write flag |

## Verification
A command write and a smart-mode data read can land in the same clock cycle. Both would start an acknowledge-plus-action sequence. The bench drives `ctrl_wr` with NACK plus STOP in the same cycle as `data_rd` while smart mode is on. It then checks that exactly NACK then STOP reach the engine, with no RDBYTE, and that the bus returns to idle. It also writes flush together with a command and checks that flush wins, with no request and no error.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  localparam int CTL_W     = 4;
  localparam int CMD_W     = 2;
  localparam int ACK_BIT   = 2;
  localparam int FLUSH_BIT = 3;

  typedef enum logic [2:0] {
    OP_ACK    = 3'd0,
    OP_NACK   = 3'd1,
    OP_RSTART = 3'd2,
    OP_RDBYTE = 3'd3,
    OP_WRBYTE = 3'd4,
    OP_STOP   = 3'd5
  } eng_op_e;

  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_OWNER = 2'd1,
    BUS_BUSY  = 2'd2
  } bus_st_e;

  typedef enum logic [CMD_W-1:0] {
    CMD_NONE   = 2'd0,
    CMD_RSTART = 2'd1,
    CMD_XFER   = 2'd2,
    CMD_STOP   = 2'd3
  } cmd_e;
endpackage

// File: rtl/i2c_cmd_decode.sv
module i2c_cmd_decode
  import i2c_cmd_pkg::*;
(
  input  logic             ctrl_wr,
  input  logic [CTL_W-1:0] ctrl_wdata,
  input  logic             ack_q,
  input  logic             smart_en,
  input  logic             data_rd,
  input  logic             flush,
  input  bus_st_e          bus_st,
  input  logic             dir_read,
  input  logic             seq_idle,
  output logic             start,
  output logic             need_ack,
  output eng_op_e          ack_op,
  output eng_op_e          follow_op,
  output logic             err
);
  cmd_e cmd;
  logic ack_eff, cmd_wr, ok, smart_go;

  assign cmd      = cmd_e'(ctrl_wdata[CMD_W-1:0]);
  // a same-write ack bit applies to the command it accompanies
  assign ack_eff  = ctrl_wr ? ctrl_wdata[ACK_BIT] : ack_q;
  assign cmd_wr   = ctrl_wr && (cmd != CMD_NONE) && !flush;
  assign ok       = seq_idle && (bus_st == BUS_OWNER);
  // command write takes precedence over a smart read in the same cycle
  assign smart_go = !cmd_wr && !flush && smart_en && data_rd && ok && dir_read;
  assign start    = (cmd_wr && ok) || smart_go;
  assign err      = cmd_wr && !ok;
  assign need_ack = dir_read;
  assign ack_op   = ack_eff ? OP_NACK : OP_ACK;

  always_comb begin
    follow_op = OP_RDBYTE;
    if (!smart_go) begin
      unique case (cmd)
        CMD_RSTART: follow_op = OP_RSTART;
        CMD_XFER:   follow_op = dir_read ? OP_RDBYTE : OP_WRBYTE;
        CMD_STOP:   follow_op = OP_STOP;
        default:    follow_op = OP_RDBYTE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_req_seq.sv
module i2c_req_seq
  import i2c_cmd_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    flush,
  input  logic    start,
  input  logic    need_ack,
  input  eng_op_e ack_op,
  input  eng_op_e follow_op,
  input  logic    data_rdy,
  input  logic    req_ready,
  input  logic    eng_done,
  output logic    req_valid,
  output eng_op_e req_op,
  output logic    seq_idle,
  output logic    consume,
  output logic    stop_done
);
  typedef enum logic [1:0] {SQ_IDLE, SQ_HOLD, SQ_REQ, SQ_WAIT} sq_e;

  sq_e     st;
  eng_op_e cur, nxt;
  logic    has_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      cur     <= OP_ACK;
      nxt     <= OP_ACK;
      has_nxt <= 1'b0;
    end else if (flush) begin
      st      <= SQ_IDLE;
      has_nxt <= 1'b0;
    end else begin
      unique case (st)
        SQ_IDLE: if (start) begin
          has_nxt <= need_ack;
          nxt     <= follow_op;
          if (need_ack) begin
            cur <= ack_op;
            st  <= SQ_REQ;
          end else begin
            cur <= follow_op;
            st  <= (follow_op == OP_WRBYTE && !data_rdy) ? SQ_HOLD : SQ_REQ;
          end
        end
        SQ_HOLD: if (data_rdy) st <= SQ_REQ;
        SQ_REQ:  if (req_ready) st <= SQ_WAIT;
        SQ_WAIT: if (eng_done) begin
          if (has_nxt) begin
            cur     <= nxt;
            has_nxt <= 1'b0;
            st      <= SQ_REQ;
          end else begin
            st <= SQ_IDLE;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign req_valid = (st == SQ_REQ);
  assign req_op    = cur;
  assign seq_idle  = (st == SQ_IDLE);
  assign consume   = req_valid && req_ready && (cur == OP_WRBYTE);
  assign stop_done = (st == SQ_WAIT) && eng_done && !has_nxt && (cur == OP_STOP);
endmodule

// File: rtl/i2c_bus_track.sv
module i2c_bus_track
  import i2c_cmd_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    flush,
  input  logic    ext_busy,
  input  logic    addr_wr,
  input  logic    addr_rw,
  input  logic    data_wr,
  input  logic    consume,
  input  logic    stop_done,
  input  logic    seq_idle,
  input  logic    cmd_fault,
  output bus_st_e bus_st,
  output logic    dir_read,
  output logic    data_rdy,
  output logic    cmd_err
);
  logic addr_ok;

  assign addr_ok = addr_wr && (bus_st != BUS_BUSY) && seq_idle;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      bus_st   <= BUS_IDLE;
      dir_read <= 1'b0;
      data_rdy <= 1'b0;
      cmd_err  <= 1'b0;
    end else begin
      if (cmd_fault || (addr_wr && !addr_ok)) cmd_err <= 1'b1;

      if (addr_ok) begin
        bus_st   <= BUS_OWNER;
        dir_read <= addr_rw;
      end else if (stop_done) begin
        bus_st <= BUS_IDLE;
      end else if (bus_st == BUS_IDLE && ext_busy) begin
        bus_st <= BUS_BUSY;
      end else if (bus_st == BUS_BUSY && !ext_busy) begin
        bus_st <= BUS_IDLE;
      end

      if (data_wr)                 data_rdy <= 1'b1;
      else if (consume || addr_ok) data_rdy <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_cmd_ctrl.sv
module i2c_cmd_ctrl
  import i2c_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smart_en,
  input  logic             ext_busy,
  input  logic             ctrl_wr,
  input  logic [CTL_W-1:0] ctrl_wdata,
  output logic [CTL_W-1:0] ctrl_rdata,
  input  logic             addr_wr,
  input  logic             addr_rw,
  input  logic             data_wr,
  input  logic             data_rd,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [2:0]       req_op,
  input  logic             eng_done,
  output logic [1:0]       bus_state,
  output logic             dir_read,
  output logic             cmd_err
);
  logic    ack_q, flush, start, need_ack, dec_err;
  logic    seq_idle, consume, stop_done, data_rdy;
  eng_op_e ack_op, follow_op, op_q;
  bus_st_e bus_st;

  assign flush = ctrl_wr && ctrl_wdata[FLUSH_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n)       ack_q <= 1'b0;
    else if (ctrl_wr) ack_q <= ctrl_wdata[ACK_BIT];
  end

  always_comb begin
    ctrl_rdata          = '0;
    ctrl_rdata[ACK_BIT] = ack_q;
  end

  i2c_cmd_decode u_dec (
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ack_q(ack_q),
    .smart_en(smart_en), .data_rd(data_rd), .flush(flush),
    .bus_st(bus_st), .dir_read(dir_read), .seq_idle(seq_idle),
    .start(start), .need_ack(need_ack), .ack_op(ack_op),
    .follow_op(follow_op), .err(dec_err)
  );

  i2c_req_seq u_seq (
    .clk(clk), .rst_n(rst_n), .flush(flush), .start(start),
    .need_ack(need_ack), .ack_op(ack_op), .follow_op(follow_op),
    .data_rdy(data_rdy), .req_ready(req_ready), .eng_done(eng_done),
    .req_valid(req_valid), .req_op(op_q), .seq_idle(seq_idle),
    .consume(consume), .stop_done(stop_done)
  );

  i2c_bus_track u_bus (
    .clk(clk), .rst_n(rst_n), .flush(flush), .ext_busy(ext_busy),
    .addr_wr(addr_wr), .addr_rw(addr_rw), .data_wr(data_wr),
    .consume(consume), .stop_done(stop_done), .seq_idle(seq_idle),
    .cmd_fault(dec_err), .bus_st(bus_st), .dir_read(dir_read),
    .data_rdy(data_rdy), .cmd_err(cmd_err)
  );

  assign req_op    = op_q;
  assign bus_state = bus_st;
endmodule

// File: rtl/i2c_cmd_ctrl_chk.sv
module i2c_cmd_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctrl_wr,
  input logic [3:0] ctrl_wdata,
  input logic       req_valid,
  input logic       req_ready,
  input logic [2:0] req_op,
  input logic [1:0] bus_state,
  input logic       dir_read,
  input logic       cmd_err
);
  logic flush_w;
  assign flush_w = ctrl_wr && ctrl_wdata[3];

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !flush_w |=> req_valid && $stable(req_op)); // R9

  AST_ACK_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_op <= 3'd1) |-> dir_read); // R3

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_w |=> (bus_state == 2'd0) && !req_valid && !cmd_err); // R10

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err && !flush_w |=> cmd_err); // R11

  AST_REQ_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> bus_state == 2'd1); // R12
endmodule

bind i2c_cmd_ctrl i2c_cmd_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
  .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
  .bus_state(bus_state), .dir_read(dir_read), .cmd_err(cmd_err)
);

// File: tb/test_i2c_cmd_ctrl.sv
module test_i2c_cmd_ctrl;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       smart_en = 1'b0, ext_busy = 1'b0, ctrl_wr = 1'b0;
  logic [3:0] ctrl_wdata = 4'd0, ctrl_rdata;
  logic       addr_wr = 1'b0, addr_rw = 1'b0, data_wr = 1'b0, data_rd = 1'b0;
  logic       req_valid, req_ready = 1'b0, eng_done = 1'b0;
  logic [2:0] req_op;
  logic [1:0] bus_state;
  logic       dir_read, cmd_err;
  int n_chk = 0, n_bad = 0;

  localparam int ACK = 0, NACK = 1, RST = 2, RDB = 3, WRB = 4, STP = 5;

  always #4 clk = ~clk;

  i2c_cmd_ctrl i_i2c_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .smart_en(smart_en), .ext_busy(ext_busy),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
    .addr_wr(addr_wr), .addr_rw(addr_rw), .data_wr(data_wr), .data_rd(data_rd),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .eng_done(eng_done), .bus_state(bus_state), .dir_read(dir_read),
    .cmd_err(cmd_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [3:0] v);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic open_tr(input logic rw);
    @(negedge clk); addr_wr = 1'b1; addr_rw = rw;
    @(negedge clk); addr_wr = 1'b0;
  endtask

  task automatic pulse_dwr();
    @(negedge clk); data_wr = 1'b1;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic pulse_drd();
    @(negedge clk); data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
  endtask

  task automatic serve(input int op, input string tag);
    chk({tag, " valid"}, int'(req_valid), 1);
    chk({tag, " op"}, int'(req_op), op);
    req_ready = 1'b1;
    @(negedge clk); req_ready = 1'b0;
    chk({tag, " accepted"}, int'(req_valid), 0);
    eng_done = 1'b1;
    @(negedge clk); eng_done = 0;
  endtask

  task automatic no_req(input int n, input string tag);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      if (req_valid) seen++;
      @(negedge clk);
    end
    chk(tag, seen, 0);
  endtask

  task automatic do_flush();
    wr_ctrl(4'h8);
  endtask

  task automatic t_reset();
    chk("R1 bus", int'(bus_state), 0);
    chk("R1 valid", int'(req_valid), 0);
    chk("R1 err", int'(cmd_err), 0);
    chk("R1 dir", int'(dir_read), 0);
    chk("R1 rdata", int'(ctrl_rdata), 0);
  endtask

  task automatic t_read_cmds();
    open_tr(1'b1);
    chk("R4 owner", int'(bus_state), 1);
    chk("R3 dir", int'(dir_read), 1);
    wr_ctrl(4'h2);
    serve(ACK, "R3 ack first");
    serve(RDB, "R4 rdbyte");
    no_req(2, "R9 idle after seq");
    wr_ctrl(4'h6);
    serve(NACK, "R5 new nack");
    serve(RDB, "R5 rdbyte");
    chk("R2 readback", int'(ctrl_rdata), 4);
    wr_ctrl(4'h1);
    serve(ACK, "R3 ack before rstart");
    serve(RST, "R4 rstart");
    chk("R4 still owner", int'(bus_state), 1);
    wr_ctrl(4'h3);
    serve(ACK, "R3 ack before stop");
    serve(STP, "R4 stop");
    chk("R4 idle after stop", int'(bus_state), 0);
    chk("R4 no err", int'(cmd_err), 0);
  endtask

  task automatic t_write_cmds();
    open_tr(1'b0);
    wr_ctrl(4'h2);
    no_req(3, "R8 wrbyte held");
    pulse_dwr();
    @(negedge clk);
    serve(WRB, "R8 wrbyte after data");
    pulse_dwr();
    no_req(2, "R7 data write no request");
    wr_ctrl(4'h2);
    serve(WRB, "R8 wrbyte immediate");
    wr_ctrl(4'h1);
    serve(RST, "R3 rstart no ack");
    wr_ctrl(4'h3);
    serve(STP, "R3 stop no ack");
    chk("R4 idle", int'(bus_state), 0);
  endtask

  task automatic t_cmd0_and_hold();
    open_tr(1'b1);
    wr_ctrl(4'h0);
    no_req(2, "R4 cmd0 nothing");
    chk("R4 cmd0 no err", int'(cmd_err), 0);
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
    no_req(2, "R9 stray done ignored");
    wr_ctrl(4'h2);
    repeat (3) @(negedge clk);
    chk("R9 held valid", int'(req_valid), 1);
    chk("R9 held op", int'(req_op), ACK);
    req_ready = 1'b1;
    @(negedge clk); req_ready = 1'b0;
    no_req(3, "R9 wait for done");
    eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
    serve(RDB, "R9 follow after done");
    do_flush();
  endtask

  task automatic t_smart();
    smart_en = 1'b1;
    open_tr(1'b1);
    pulse_drd();
    serve(ACK, "R6 smart ack");
    serve(RDB, "R6 smart rdbyte");
    pulse_dwr();
    no_req(2, "R7 data write in read dir");
    smart_en = 1'b0;
    pulse_drd();
    no_req(2, "R6 smart off");
    smart_en = 1'b1;
    @(negedge clk);
    ctrl_wr = 1'b1; ctrl_wdata = 4'h7; data_rd = 1'b1;
    @(negedge clk);
    ctrl_wr = 1'b0; data_rd = 1'b0;
    serve(NACK, "R13 cmd wins nack");
    serve(STP, "R13 cmd wins stop");
    no_req(2, "R13 no smart read");
    chk("R13 idle", int'(bus_state), 0);
    smart_en = 1'b0;
  endtask

  task automatic t_err_flush();
    open_tr(1'b1);
    wr_ctrl(4'h2);
    wr_ctrl(4'h1);
    chk("R11 busy cmd err", int'(cmd_err), 1);
    serve(ACK, "R11 original ack");
    serve(RDB, "R11 original rdbyte");
    no_req(1, "R11 refused cmd dropped");
    chk("R11 sticky", int'(cmd_err), 1);
    wr_ctrl(4'h4);
    chk("R10 flush0 owner kept", int'(bus_state), 1);
    chk("R10 flush0 err kept", int'(cmd_err), 1);
    do_flush();
    chk("R10 flush idle", int'(bus_state), 0);
    chk("R10 flush err clr", int'(cmd_err), 0);
    wr_ctrl(4'h2);
    no_req(2, "R12 no req after flush");
    chk("R12 err after flush", int'(cmd_err), 1);
    do_flush();
    open_tr(1'b1);
    wr_ctrl(4'hA);
    no_req(2, "R10 flush beats cmd");
    chk("R10 flush+cmd no err", int'(cmd_err), 0);
    chk("R10 flush+cmd idle", int'(bus_state), 0);
    open_tr(1'b1);
    wr_ctrl(4'h2);
    chk("R10 pending valid", int'(req_valid), 1);
    do_flush();
    no_req(2, "R10 pending dropped");
    open_tr(1'b0);
    pulse_dwr();
    do_flush();
    open_tr(1'b0);
    wr_ctrl(4'h2);
    no_req(3, "R10 data discarded");
    do_flush();
  endtask

  task automatic t_busy();
    @(negedge clk); ext_busy = 1'b1;
    @(negedge clk);
    chk("R14 busy", int'(bus_state), 2);
    open_tr(1'b1);
    chk("R11 addr refused", int'(cmd_err), 1);
    chk("R14 still busy", int'(bus_state), 2);
    ext_busy = 1'b0;
    @(negedge clk);
    chk("R14 back idle", int'(bus_state), 0);
    do_flush();
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_cmds();
    t_write_cmds();
    t_cmd0_and_hold();
    t_smart();
    t_err_flush();
    t_busy();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule